// File: doc/BRIEF.md
# Multi-page-size TLB

A fully associative translation cache for a device-side address translator. Each slot holds a tag word and a translation word. The tag word carries a virtual page tag, a page-size code, a valid flag and a preserved flag. The translation word carries a physical page plus three access attributes. Every slot compares only the address bits that its own page size leaves significant, so 16 MB, 1 MB, 64 KB and 4 KB pages can sit side by side in the same array.

Software stages a tag word and a translation word and then pulses a load strobe. The slot that receives the entry is chosen by a victim pointer, which is held in a lock word together with a lock base. After each load the pointer steps forward and wraps back to the base, so automatic replacement never reaches the slots below the base. The slot under the victim pointer can be read back. Two flushes are available. A global flush drops every entry that is not preserved. A single-entry flush drops the entries whose tag matches the staged tag word.

A lookup request takes a 32-bit virtual address. One cycle later the block reports exactly one of three results: a hit with the translated address and attributes, a miss, or a multi-hit fault.

Top module: `mpage_tlb`

## Requirements
- R1: After reset every slot is invalid, the lock word reads 0, the read-back outputs are 0 and all lookup outputs are 0.
- R2: A load pulse writes the staged tag and translation words into the slot at the victim pointer and always sets the valid flag (tag bit 2). The read-back outputs show the tag and translation words of the slot at the current victim pointer.
- R3: Tag word layout: tag in bits [31:12], preserved in bit 3, valid in bit 2, page size in bits [1:0]. The page-size codes are 0 = 1 MB, 1 = 64 KB, 2 = 4 KB and 3 = 16 MB. A valid slot matches when the virtual address equals its tag under the mask for its size: 0xFFF00000, 0xFFFF0000, 0xFFFFF000 and 0xFF000000 respectively.
- R4: On a single match, the translated address is (physical AND mask) OR (virtual AND NOT mask). The attribute output is {bit 9 endian, bits [8:7] element size, bit 6 mixed}, taken from the translation word.
- R5: A lookup result appears in the cycle after the request, with the result-valid output high and exactly one of hit, miss or multi-hit high. With no request, all lookup outputs are 0.
- R6: When no valid slot matches, the miss output is high and the address and attributes are 0.
- R7: When more than one valid slot matches, the multi-hit output is high and the address and attributes are 0.
- R8: Lock word layout: base in bits [14:10] and victim in bits [8:4]; it reads back in the same layout with all other bits 0. After a load the victim increments by one, and from the last slot it wraps to the base.
- R9: A global flush clears the valid flag of every slot whose preserved flag is 0 and leaves preserved slots valid.
- R10: A single-entry flush clears the valid flag of every slot whose tag, under that slot's own size mask, equals the staged tag word, whatever its preserved flag.
- R11: A lock write in the same cycle as a load sets the victim to the written value and does not advance it. A load in the same cycle as a flush leaves the loaded slot valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stage_cam_i | input | 32 | Staged tag word |
| stage_ram_i | input | 32 | Staged translation word |
| load_i | input | 1 | Load strobe |
| gflush_i | input | 1 | Global flush strobe |
| eflush_i | input | 1 | Single-entry flush strobe (uses staged tag word) |
| lock_wr_i | input | 1 | Lock word write strobe |
| lock_wdata_i | input | 32 | Lock word write data |
| lock_rdata_o | output | 32 | Lock word read-back |
| rd_cam_o | output | 32 | Tag word of slot at victim pointer |
| rd_ram_o | output | 32 | Translation word of slot at victim pointer |
| lk_req_i | input | 1 | Lookup request |
| lk_va_i | input | 32 | Lookup virtual address |
| lk_vld_o | output | 1 | Lookup result valid |
| lk_hit_o | output | 1 | Single match |
| lk_miss_o | output | 1 | No match |
| lk_multi_o | output | 1 | Multi-hit fault |
| lk_pa_o | output | 32 | Translated address |
| lk_attr_o | output | 4 | {endian, element size, mixed} |

## Verification
The array is filled with one entry of each page size. Each entry is then looked up with an address that differs from its tag only in bits inside its page, which must hit, and with an address that differs in the lowest tag bit its mask keeps, which must miss. Together these two probes show whether each slot applies its own mask rather than a fixed one. A 1 MB entry is placed over an existing 4 KB one to force a multi-hit. Removing the 1 MB entry with a single-entry flush then tells a tag-matched flush apart from a flush by slot. A preserved entry and an ordinary entry are compared across a global flush. Victim stepping is checked at the wrap to the base, and again when a load coincides with a lock write or with a flush.

// File: rtl/mpage_tlb_pkg.sv
package mpage_tlb_pkg;
   localparam int VAW          = 32;
   localparam int CAM_P        = 3;
   localparam int CAM_V        = 2;
   localparam int RAM_ENDIAN   = 9;
   localparam int RAM_ELSZ_LO  = 7;
   localparam int RAM_MIXED    = 6;
   localparam int LOCK_BASE_LO = 10;
   localparam int LOCK_VICT_LO = 4;
   localparam int LOCK_FW      = 5;
   localparam int ATTRW        = 4;

   typedef enum logic [1:0] {
      PG_1M  = 2'd0,
      PG_64K = 2'd1,
      PG_4K  = 2'd2,
      PG_16M = 2'd3
   } pg_size_e;

   function automatic logic [VAW-1:0] pg_mask(input logic [1:0] sz);
      case (pg_size_e'(sz))
         PG_16M:  pg_mask = 32'hFF00_0000;
         PG_1M:   pg_mask = 32'hFFF0_0000;
         PG_64K:  pg_mask = 32'hFFFF_0000;
         default: pg_mask = 32'hFFFF_F000;
      endcase
   endfunction
endpackage

// File: rtl/mpage_tlb_entry.sv
module mpage_tlb_entry
   import mpage_tlb_pkg::*;
(
   input  logic           clk,
   input  logic           rst_n,
   input  logic           we_i,
   input  logic [VAW-1:0] wcam_i,
   input  logic [VAW-1:0] wram_i,
   input  logic           gflush_i,
   input  logic           eflush_i,
   input  logic [VAW-1:0] ftag_i,
   input  logic [VAW-1:0] va_i,
   output logic           hit_o,
   output logic [VAW-1:0] mask_o,
   output logic [VAW-1:0] cam_o,
   output logic [VAW-1:0] ram_o
);
   logic [VAW-1:0] cam_q, ram_q;
   logic [VAW-1:0] mask;
   logic           tag_eq_flush;

   assign mask         = pg_mask(cam_q[1:0]);
   assign tag_eq_flush = ((cam_q ^ ftag_i) & mask) == '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cam_q <= '0;
         ram_q <= '0;
      end else begin
         if (gflush_i && !cam_q[CAM_P]) cam_q[CAM_V] <= 1'b0;
         if (eflush_i && tag_eq_flush)  cam_q[CAM_V] <= 1'b0;
         if (we_i) begin
            cam_q        <= wcam_i;
            cam_q[CAM_V] <= 1'b1;
            ram_q        <= wram_i;
         end
      end
   end

   assign hit_o  = cam_q[CAM_V] && (((va_i ^ cam_q) & mask) == '0);
   assign mask_o = mask;
   assign cam_o  = cam_q;
   assign ram_o  = ram_q;

   AST_LOAD_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> cam_q[CAM_V]); // R2
   AST_PRESERVED_SURVIVES: assert property (@(posedge clk) disable iff (!rst_n)
      (gflush_i && !eflush_i && !we_i && cam_q[CAM_P] && cam_q[CAM_V]) |=> cam_q[CAM_V]); // R9
   AST_GFLUSH_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (gflush_i && !we_i && !cam_q[CAM_P]) |=> !cam_q[CAM_V]); // R9
endmodule

// File: rtl/mpage_tlb_ctrl.sv
module mpage_tlb_ctrl
   import mpage_tlb_pkg::*;
#(
   parameter int ENTRIES = 32,
   localparam int IDXW   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load_i,
   input  logic            lock_wr_i,
   input  logic [VAW-1:0]  lock_wdata_i,
   output logic [IDXW-1:0] victim_o,
   output logic [VAW-1:0]  lock_rdata_o
);
   localparam logic [IDXW-1:0] LAST = IDXW'(ENTRIES - 1);

   logic [IDXW-1:0] base_q, victim_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q   <= '0;
         victim_q <= '0;
      end else if (lock_wr_i) begin
         base_q   <= lock_wdata_i[LOCK_BASE_LO +: IDXW];
         victim_q <= lock_wdata_i[LOCK_VICT_LO +: IDXW];
      end else if (load_i) begin
         victim_q <= (victim_q >= LAST) ? base_q : victim_q + 1'b1;
      end
   end

   always_comb begin
      lock_rdata_o = '0;
      lock_rdata_o[LOCK_BASE_LO +: IDXW] = base_q;
      lock_rdata_o[LOCK_VICT_LO +: IDXW] = victim_q;
   end

   assign victim_o = victim_q;

   AST_VICTIM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && !lock_wr_i && victim_q < LAST) |=> victim_q == $past(victim_q) + 1'b1); // R8
   AST_VICTIM_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && !lock_wr_i && victim_q >= LAST) |=> victim_q == $past(base_q)); // R8
   AST_LOCK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      lock_wr_i |=> victim_q == $past(lock_wdata_i[LOCK_VICT_LO +: IDXW])); // R11
endmodule

// File: rtl/mpage_tlb_lookup.sv
module mpage_tlb_lookup
   import mpage_tlb_pkg::*;
#(
   parameter int ENTRIES = 32,
   localparam int CW     = $clog2(ENTRIES + 1)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          req_i,
   input  logic [VAW-1:0]                va_i,
   input  logic [ENTRIES-1:0]            hit_vec_i,
   input  logic [ENTRIES-1:0][VAW-1:0]   mask_arr_i,
   input  logic [ENTRIES-1:0][VAW-1:0]   ram_arr_i,
   output logic                          vld_o,
   output logic                          hit_o,
   output logic                          miss_o,
   output logic                          multi_o,
   output logic [VAW-1:0]                pa_o,
   output logic [ATTRW-1:0]              attr_o
);
   logic [CW-1:0]    cnt;
   logic [VAW-1:0]   pa_sel;
   logic [ATTRW-1:0] attr_sel;

   always_comb begin
      cnt      = CW'($countones(hit_vec_i));
      pa_sel   = '0;
      attr_sel = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (hit_vec_i[i]) begin
            pa_sel   = pa_sel | (ram_arr_i[i] & mask_arr_i[i]) | (va_i & ~mask_arr_i[i]);
            attr_sel = attr_sel | {ram_arr_i[i][RAM_ENDIAN],
                                   ram_arr_i[i][RAM_ELSZ_LO +: 2],
                                   ram_arr_i[i][RAM_MIXED]};
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_o   <= 1'b0;
         hit_o   <= 1'b0;
         miss_o  <= 1'b0;
         multi_o <= 1'b0;
         pa_o    <= '0;
         attr_o  <= '0;
      end else begin
         vld_o   <= req_i;
         hit_o   <= req_i && (cnt == CW'(1));
         miss_o  <= req_i && (cnt == '0);
         multi_o <= req_i && (cnt > CW'(1));
         pa_o    <= (req_i && cnt == CW'(1)) ? pa_sel   : '0;
         attr_o  <= (req_i && cnt == CW'(1)) ? attr_sel : '0;
      end
   end

   AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      vld_o |-> $onehot({hit_o, miss_o, multi_o})); // R5
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !vld_o |-> !(hit_o || miss_o || multi_o) && pa_o == '0); // R5
   AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_o || multi_o) |-> (pa_o == '0 && attr_o == '0)); // R7
endmodule

// File: rtl/mpage_tlb.sv
module mpage_tlb
   import mpage_tlb_pkg::*;
#(
   parameter int ENTRIES = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [31:0] stage_cam_i,
   input  logic [31:0] stage_ram_i,
   input  logic        load_i,
   input  logic        gflush_i,
   input  logic        eflush_i,
   input  logic        lock_wr_i,
   input  logic [31:0] lock_wdata_i,
   output logic [31:0] lock_rdata_o,
   output logic [31:0] rd_cam_o,
   output logic [31:0] rd_ram_o,
   input  logic        lk_req_i,
   input  logic [31:0] lk_va_i,
   output logic        lk_vld_o,
   output logic        lk_hit_o,
   output logic        lk_miss_o,
   output logic        lk_multi_o,
   output logic [31:0] lk_pa_o,
   output logic [3:0]  lk_attr_o
);
   localparam int IDXW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   if (ENTRIES < 2 || ENTRIES > (1 << LOCK_FW)) begin : g_bad_entries
      $error("mpage_tlb: ENTRIES must lie in 2..32");
   end

   logic [IDXW-1:0]              victim;
   logic [ENTRIES-1:0]           hit_vec;
   logic [ENTRIES-1:0][VAW-1:0]  mask_arr, cam_arr, ram_arr;

   mpage_tlb_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .load_i       (load_i),
      .lock_wr_i    (lock_wr_i),
      .lock_wdata_i (lock_wdata_i),
      .victim_o     (victim),
      .lock_rdata_o (lock_rdata_o)
   );

   for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
      mpage_tlb_entry u_entry (
         .clk      (clk),
         .rst_n    (rst_n),
         .we_i     (load_i && victim == IDXW'(i)),
         .wcam_i   (stage_cam_i),
         .wram_i   (stage_ram_i),
         .gflush_i (gflush_i),
         .eflush_i (eflush_i),
         .ftag_i   (stage_cam_i),
         .va_i     (lk_va_i),
         .hit_o    (hit_vec[i]),
         .mask_o   (mask_arr[i]),
         .cam_o    (cam_arr[i]),
         .ram_o    (ram_arr[i])
      );
   end

   always_comb begin
      rd_cam_o = '0;
      rd_ram_o = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (victim == IDXW'(i)) begin
            rd_cam_o = cam_arr[i];
            rd_ram_o = ram_arr[i];
         end
      end
   end

   mpage_tlb_lookup #(.ENTRIES(ENTRIES)) u_lookup (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_i      (lk_req_i),
      .va_i       (lk_va_i),
      .hit_vec_i  (hit_vec),
      .mask_arr_i (mask_arr),
      .ram_arr_i  (ram_arr),
      .vld_o      (lk_vld_o),
      .hit_o      (lk_hit_o),
      .miss_o     (lk_miss_o),
      .multi_o    (lk_multi_o),
      .pa_o       (lk_pa_o),
      .attr_o     (lk_attr_o)
   );

   AST_REQ_GIVES_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      lk_req_i |=> lk_vld_o); // R5
   AST_MULTI_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_req_i && $countones(hit_vec) > 1) |=> lk_multi_o); // R7
   AST_NONE_IS_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_req_i && hit_vec == '0) |=> lk_miss_o); // R6
endmodule

// File: tb/mpage_tlb_test.sv
module mpage_tlb_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] stage_cam_i = '0, stage_ram_i = '0, lock_wdata_i = '0, lk_va_i = '0;
   logic        load_i = 1'b0, gflush_i = 1'b0, eflush_i = 1'b0, lock_wr_i = 1'b0, lk_req_i = 1'b0;
   logic [31:0] lock_rdata_o, rd_cam_o, rd_ram_o, lk_pa_o;
   logic        lk_vld_o, lk_hit_o, lk_miss_o, lk_multi_o;
   logic [3:0]  lk_attr_o;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;

   mpage_tlb uut (.*);

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic lock_set(input int base, input int vict);
      @(negedge clk);
      lock_wr_i = 1'b1;
      lock_wdata_i = (base << 10) | (vict << 4);
      @(negedge clk);
      lock_wr_i = 1'b0;
   endtask

   task automatic load(input logic [31:0] cam, input logic [31:0] ram);
      @(negedge clk);
      stage_cam_i = cam; stage_ram_i = ram; load_i = 1'b1;
      @(negedge clk);
      load_i = 1'b0;
   endtask

   // flags {vld,hit,miss,multi}
   task automatic lookup(input string tag, input logic [31:0] va, input logic [3:0] flags,
                         input logic [31:0] pa, input logic [3:0] attr);
      @(negedge clk);
      lk_req_i = 1'b1; lk_va_i = va;
      @(negedge clk);
      lk_req_i = 1'b0;
      chk({tag, " flags"}, {28'd0, lk_vld_o, lk_hit_o, lk_miss_o, lk_multi_o}, {28'd0, flags});
      chk({tag, " pa"}, lk_pa_o, pa);
      chk({tag, " attr"}, {28'd0, lk_attr_o}, {28'd0, attr});
   endtask

   task automatic t_reset;
      chk("R1 lock", lock_rdata_o, 32'h0);
      chk("R1 rdcam", rd_cam_o, 32'h0);
      chk("R1 out", {lk_vld_o, lk_hit_o, lk_miss_o, lk_multi_o, lk_attr_o, lk_pa_o[23:0]}, 32'h0);
      lookup("R1 empty miss", 32'h1234_5ABC, 4'b1010, 32'h0, 4'h0);
   endtask

   task automatic t_load_sizes;
      lock_set(0, 0);
      load(32'h1234_5002, 32'hABCD_E340);
      chk("R8 step", lock_rdata_o, 32'h0000_0010);
      lock_set(0, 0);
      chk("R2 rdcam valid forced", rd_cam_o, 32'h1234_5006);
      chk("R2 rdram", rd_ram_o, 32'hABCD_E340);
      lookup("R4 4K hit", 32'h1234_5ABC, 4'b1100, 32'hABCD_EABC, 4'hD);
      lookup("R3 4K tag miss", 32'h1234_6ABC, 4'b1010, 32'h0, 4'h0);
      lock_set(0, 1);
      load(32'h5500_0003, 32'h7700_0000);
      load(32'h6001_0001, 32'h9002_0000);
      load(32'h4010_0000, 32'h8030_0000);
      lookup("R3 16M hit", 32'h55AB_CDEF, 4'b1100, 32'h77AB_CDEF, 4'h0);
      lookup("R3 16M miss", 32'h56AB_CDEF, 4'b1010, 32'h0, 4'h0);
      lookup("R3 64K hit", 32'h6001_BEEF, 4'b1100, 32'h9002_BEEF, 4'h0);
      lookup("R3 64K miss", 32'h6002_BEEF, 4'b1010, 32'h0, 4'h0);
      lookup("R3 1M hit", 32'h401F_FFFF, 4'b1100, 32'h803F_FFFF, 4'h0);
      lookup("R6 1M miss", 32'h4020_0000, 4'b1010, 32'h0, 4'h0);
   endtask

   task automatic t_multi_and_eflush;
      load(32'h1230_0000, 32'hC000_0000);
      lookup("R7 multi", 32'h1234_5ABC, 4'b1001, 32'h0, 4'h0);
      @(negedge clk);
      stage_cam_i = 32'h1230_0000; eflush_i = 1'b1;
      @(negedge clk);
      eflush_i = 1'b0;
      lookup("R10 tag flush", 32'h1234_5ABC, 4'b1100, 32'hABCD_EABC, 4'hD);
      lookup("R10 other kept", 32'h55AB_CDEF, 4'b1100, 32'h77AB_CDEF, 4'h0);
   endtask

   task automatic t_wrap;
      lock_set(30, 30);
      load(32'h0000_1002, 32'h0);
      chk("R8 to last", lock_rdata_o, (32'd30 << 10) | (32'd31 << 4));
      load(32'h0000_2002, 32'h0);
      chk("R8 wrap to base", lock_rdata_o, (32'd30 << 10) | (32'd30 << 4));
      chk("R2 rd at wrapped slot", rd_cam_o, 32'h0000_1006);
   endtask

   task automatic t_gflush;
      lock_set(0, 5);
      load(32'h6600_000B, 32'h1100_0000);
      @(negedge clk);
      gflush_i = 1'b1;
      @(negedge clk);
      gflush_i = 1'b0;
      lookup("R9 preserved kept", 32'h6612_3456, 4'b1100, 32'h1112_3456, 4'h0);
      lookup("R9 plain dropped", 32'h55AB_CDEF, 4'b1010, 32'h0, 4'h0);
      lookup("R9 plain dropped 1M", 32'h401F_FFFF, 4'b1010, 32'h0, 4'h0);
   endtask

   task automatic t_priority;
      @(negedge clk);
      lock_wr_i = 1'b1; lock_wdata_i = 32'd7 << 4;
      stage_cam_i = 32'h3A00_0003; stage_ram_i = 32'h3B00_0000; load_i = 1'b1;
      @(negedge clk);
      lock_wr_i = 1'b0; load_i = 1'b0;
      chk("R11 lock wins", lock_rdata_o, 32'h0000_0070);
      lock_set(0, 6);
      chk("R11 load landed", rd_cam_o, 32'h3A00_0007);
      lock_set(0, 8);
      @(negedge clk);
      stage_cam_i = 32'h7000_0003; stage_ram_i = 32'h7100_0000; load_i = 1'b1; gflush_i = 1'b1;
      @(negedge clk);
      load_i = 1'b0; gflush_i = 1'b0;
      lookup("R11 load beats flush", 32'h7000_0010, 4'b1100, 32'h7100_0010, 4'h0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_load_sizes();
      t_multi_and_eflush();
      t_wrap();
      t_gflush();
      t_priority();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule